// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Timer

This block is a clocked pulse stretcher. Three asynchronous control lines are involved. One is a gate that is active low. One is a gate that is active high. The third is an active-low clear. The block watches all three for a qualifying change. When one occurs, it drives a single pulse whose length in clock cycles is taken from a length input at that moment. A down-counter sets the pulse width in place of analog timing parts. Any further qualifying change during a pulse reloads the counter, so a steady stream of triggers can keep the output asserted without a gap.

Each control line first passes through a two-stage synchroniser. The block then compares the synchronised level with its value one cycle earlier. A pulse starts from any of three gated events:
- a rise of the high-active gate while the low-active gate is low;
- a fall of the low-active gate while the high-active gate is high;
- a release of clear while both gates sit at their enabling levels.

Holding clear low stops any pulse and blocks every event. Both the pulse and its complement are driven.

Top module: `retrig_oneshot`

## Requirements
- R1: With `gate_n` low and `clear_n` high, a low-to-high change on `gate_p` makes `pulse_q` go high at the third rising clock edge after the change. It stays high for exactly `pulse_len` cycles and then returns low.
- R2: With `gate_p` high and `clear_n` high, a high-to-low change on `gate_n` starts a pulse with the same timing and length as in R1.
- R3: With `gate_n` low and `gate_p` high, a low-to-high change on `clear_n` starts a pulse with the same timing and length as in R1.
- R4: A rise of `gate_p` while `gate_n` is high starts no pulse. A fall of `gate_n` while `gate_p` is low also starts no pulse.
- R5: The pulse length is sampled once, in the cycle the trigger loads the counter. Later changes to `pulse_len` do not alter a pulse already running.
- R6: A qualifying event during a pulse reloads the counter. The output stays high without a gap and falls `pulse_len` cycles after the last trigger loaded the counter.
- R7: A fall of `clear_n` forces `pulse_q` low at the third rising edge after the change. While clear stays low, every gate change is ignored.
- R8: A trigger that captures a length of zero gives no pulse. If such a trigger arrives during a pulse, it ends that pulse.
- R9: During and after reset `pulse_q` is low. Gate levels that already enable a trigger while reset is held do not cause a pulse after reset is released.
- R10: `pulse_qn` is always the complement of `pulse_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_n | input | 1 | Asynchronous trigger gate, active low |
| gate_p | input | 1 | Asynchronous trigger gate, active high |
| clear_n | input | 1 | Asynchronous clear, active low; its release can also trigger |
| pulse_len | input | LEN_W | Pulse length in clock cycles, captured at trigger |
| pulse_q | output | 1 | Pulse output |
| pulse_qn | output | 1 | Complement of the pulse output |

## Verification
The checker assumes that every control line holds each level long enough for both synchroniser stages to capture it. A level that changes and changes back inside one cycle is therefore outside its scope. It also assumes that `pulse_len` is stable in the cycle the counter loads. The stimulus changes lines only on falling clock edges and keeps each level for at least two cycles. It alters `pulse_len` only at least one cycle after the load it belongs to. The edge-detect warm-up after reset is exercised by holding an enabling gate pattern throughout reset.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef struct packed {
        logic gate_n;
        logic gate_p;
        logic clear_n;
    } ctrl_lines_t;

    localparam ctrl_lines_t LINES_IDLE = '{gate_n: 1'b1, gate_p: 1'b0, clear_n: 1'b1};
    localparam int          LINE_W     = $bits(ctrl_lines_t);

    typedef enum logic [1:0] {
        EVT_NONE,
        EVT_P_RISE,
        EVT_N_FALL,
        EVT_CLR_RELEASE
    } trig_evt_t;

    // Decode which gated event (if any) the current/previous levels describe.
    function automatic trig_evt_t decode_event(ctrl_lines_t now, ctrl_lines_t prev);
        if (!now.gate_n && !prev.gate_p && now.gate_p)
            return EVT_P_RISE;
        else if (now.gate_p && prev.gate_n && !now.gate_n)
            return EVT_N_FALL;
        else if (!now.gate_n && now.gate_p && !prev.clear_n && now.clear_n)
            return EVT_CLR_RELEASE;
        else
            return EVT_NONE;
    endfunction

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/oneshot_edge.sv
module oneshot_edge
    import oneshot_pkg::*;
#(
    parameter int WARMUP = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  ctrl_lines_t lvl,
    output logic        fire
);
    localparam int WARM_W = $clog2(WARMUP + 1);

    ctrl_lines_t       prev_lvl;
    logic [WARM_W-1:0] warm_cnt;
    logic              armed;
    trig_evt_t         evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= LINES_IDLE;
            warm_cnt <= '0;
        end else begin
            prev_lvl <= lvl;
            if (!armed) warm_cnt <= warm_cnt + 1'b1;
        end
    end

    assign armed = (warm_cnt == WARM_W'(WARMUP));
    assign evt   = decode_event(lvl, prev_lvl);
    assign fire  = armed && lvl.clear_n && (evt != EVT_NONE);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] count,
    output logic             active
);
    always_ff @(posedge clk) begin
        if (rst)               count <= '0;
        else if (!clr_n)       count <= '0;
        else if (load)         count <= len;
        else if (count != '0)  count <= count - 1'b1;
    end

    assign active = (count != '0);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_n,
    input  logic             gate_p,
    input  logic             clear_n,
    input  logic [LEN_W-1:0] pulse_len,
    output logic             pulse_q,
    output logic             pulse_qn
);
    localparam int WARMUP = SYNC_STAGES + 1;

    ctrl_lines_t      raw_lvl;
    ctrl_lines_t      sync_lvl;
    logic [LINE_W-1:0] sync_bits;
    logic             clr_lvl;
    logic             fire;
    logic [LEN_W-1:0] count;
    logic             active;

    assign raw_lvl = '{gate_n: gate_n, gate_p: gate_p, clear_n: clear_n};

    oneshot_sync #(
        .W       (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINES_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (sync_bits)
    );

    assign sync_lvl = ctrl_lines_t'(sync_bits);
    assign clr_lvl  = sync_lvl.clear_n;

    oneshot_edge #(
        .WARMUP (WARMUP)
    ) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lvl),
        .fire (fire)
    );

    oneshot_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_lvl),
        .load   (fire),
        .len    (pulse_len),
        .count  (count),
        .active (active)
    );

    assign pulse_q  = active;
    assign pulse_qn = ~active;
endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_lvl,
    input logic             fire,
    input logic [LEN_W-1:0] pulse_len,
    input logic [LEN_W-1:0] count,
    input logic             pulse_q
);
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        !clr_lvl |=> (count == '0) && !pulse_q);  // R7

    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (rst)
        (fire && clr_lvl) |=> (count == $past(pulse_len)));  // R5

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (clr_lvl && !fire && count != '0) |=> (count == LEN_W'($past(count) - 1'b1)));  // R1

    AST_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_q) |-> $past(fire));  // R4

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pulse_q);  // R9

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (fire && pulse_len == '0) |=> !pulse_q);  // R8
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_lvl   (clr_lvl),
    .fire      (fire),
    .pulse_len (pulse_len),
    .count     (count),
    .pulse_q   (pulse_q)
);

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             gate_n = 1'b0;
    logic             gate_p = 1'b1;
    logic             clear_n = 1'b1;
    logic [LEN_W-1:0] pulse_len = 8'd5;
    logic             pulse_q;
    logic             pulse_qn;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int    at;
        logic  q;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;  // 50 MHz

    retrig_oneshot #(.LEN_W(LEN_W)) u_retrig_oneshot (
        .clk       (clk),
        .rst       (rst),
        .gate_n    (gate_n),
        .gate_p    (gate_p),
        .clear_n   (clear_n),
        .pulse_len (pulse_len),
        .pulse_q   (pulse_q),
        .pulse_qn  (pulse_qn)
    );

    task automatic push(int from, int upto, logic val, string tag);
        for (int i = from; i <= upto; i++) begin
            exp_t e;
            e.at = i; e.q = val; e.tag = tag;
            sb.push_back(e);
        end
    endtask

    // Expected shape of an isolated trigger applied in cycle c0 with length n.
    task automatic expect_trig(int c0, int n, string tag);
        push(c0 + 1, c0 + 2, 1'b0, tag);
        if (n > 0) push(c0 + 3, c0 + 2 + n, 1'b1, tag);
        push(c0 + 3 + n, c0 + 5 + n, 1'b0, tag);
    endtask

    task automatic at_cycle(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items at mid-high phase after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pulse_q !== e.q || pulse_qn !== ~e.q) begin
                    errors++;
                    $display("FAIL %s cycle %0d: q=%b qn=%b expected q=%b qn=%b",
                             e.tag, cyc, pulse_q, pulse_qn, e.q, ~e.q);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung, expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0;
        // R9: enabling levels held through reset, then released
        idle(5);
        c0 = cyc;
        push(c0 + 1, c0 + 8, 1'b0, "R9");
        push(c0 + 1, c0 + 8, 1'b0, "R10");
        rst = 1'b0;
        idle(9);

        // R1: gate_p rises with gate_n low
        gate_p = 1'b0; idle(4);
        c0 = cyc; pulse_len = 8'd5; gate_p = 1'b1;
        expect_trig(c0, 5, "R1");
        idle(12);

        // R2: gate_n falls with gate_p high
        gate_n = 1'b1; idle(4);
        c0 = cyc; gate_n = 1'b0;
        expect_trig(c0, 5, "R2");
        idle(12);

        // R4: wrong gating levels
        gate_n = 1'b1; gate_p = 1'b0; idle(4);
        c0 = cyc; gate_p = 1'b1;
        push(c0 + 1, c0 + 8, 1'b0, "R4");
        idle(9);
        gate_p = 1'b0; idle(4);
        c0 = cyc; gate_n = 1'b0;
        push(c0 + 1, c0 + 8, 1'b0, "R4");
        idle(9);

        // R7: gate_p rise while clear is low is ignored
        c0 = cyc; clear_n = 1'b0; gate_p = 1'b1;
        push(c0 + 1, c0 + 6, 1'b0, "R7");
        idle(6);
        // R3: clear release with gates enabling
        c0 = cyc; clear_n = 1'b1;
        expect_trig(c0, 5, "R3");
        idle(12);

        // R5: length changed after capture
        gate_p = 1'b0; idle(3);
        c0 = cyc; pulse_len = 8'd7; gate_p = 1'b1;
        expect_trig(c0, 7, "R5");
        at_cycle(c0 + 4); pulse_len = 8'd2;
        idle(10);

        // R6: retrigger stretches pulse
        pulse_len = 8'd6; gate_p = 1'b0; idle(3);
        c0 = cyc; gate_p = 1'b1;
        push(c0 + 1, c0 + 2, 1'b0, "R6");
        push(c0 + 3, c0 + 13, 1'b1, "R6");
        push(c0 + 14, c0 + 16, 1'b0, "R6");
        at_cycle(c0 + 2); gate_p = 1'b0;
        at_cycle(c0 + 5); gate_p = 1'b1;
        at_cycle(c0 + 17);

        // R7: clear terminates pulse and blocks triggers
        pulse_len = 8'd8; gate_p = 1'b0; idle(3);
        c0 = cyc; gate_p = 1'b1;
        push(c0 + 1, c0 + 2, 1'b0, "R7");
        push(c0 + 3, c0 + 5, 1'b1, "R7");
        push(c0 + 6, c0 + 18, 1'b0, "R7");
        at_cycle(c0 + 3);  clear_n = 1'b0;
        at_cycle(c0 + 4);  gate_p = 1'b0;
        at_cycle(c0 + 7);  gate_p = 1'b1;
        at_cycle(c0 + 10); gate_p = 1'b0;
        at_cycle(c0 + 13); clear_n = 1'b1;
        at_cycle(c0 + 19);

        // R8: zero length gives no pulse
        pulse_len = 8'd0; idle(2);
        c0 = cyc; gate_p = 1'b1;
        expect_trig(c0, 0, "R8");
        idle(7);

        // R8: zero-length retrigger ends a running pulse
        pulse_len = 8'd6; gate_p = 1'b0; idle(3);
        c0 = cyc; gate_p = 1'b1;
        push(c0 + 1, c0 + 2, 1'b0, "R8");
        push(c0 + 3, c0 + 6, 1'b1, "R8");
        push(c0 + 7, c0 + 10, 1'b0, "R8");
        at_cycle(c0 + 2); gate_p = 1'b0;
        at_cycle(c0 + 4); pulse_len = 8'd0; gate_p = 1'b1;
        at_cycle(c0 + 11);

        idle(2);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule